// File: doc/BRIEF.md
# Speculative Load Violation Detector

This block sits beside the load/store unit of an out-of-order core and remembers every load that has executed ahead of older stores whose addresses were still unknown. Each remembered load occupies one slot holding an occupied flag, its instruction number and a partial address tag made of the low address bits. Loads enter through a valid/ready execute port and leave when they commit or when an abort sweeps away the tail of the instruction window.

When a store finally resolves its address, the store's instruction number and address are presented on the check port. Every slot is compared in parallel. Any occupied slot whose tag equals the store's tag and whose load is younger than the store is a memory-order violation. One cycle later the block raises a violation pulse carrying the instruction number of the oldest such load. The pipeline uses it to squash that load and everything after it. The squash itself happens outside this block.

Only the low address bits take part in the compare. This keeps the comparators narrow and can only add false violations, never miss a real one. Back-pressure on the execute port: a load is taken only in a cycle where both `exe_valid` and `exe_ready` are high. `exe_ready` is low exactly when every slot is occupied. A load offered while ready is low is not recorded, and the sender must hold or replay it.

Top module: `slvd_detector`

## Requirements
- R1: After reset no slot is occupied, `exe_ready` is 1 and `viol_valid` is 0.
- R2: A load is recorded when `exe_valid` and `exe_ready` are both high at a clock edge, keeping `exe_inum` and tag `exe_addr[11:0]`. `exe_ready` is 0 exactly when all 16 slots are occupied, and a load offered while it is 0 is not recorded.
- R3: A commit (`cmt_valid`) frees every occupied slot whose instruction number equals `cmt_inum`, starting at the next cycle.
- R4: An abort (`abt_valid`) frees every occupied slot whose instruction number is the same age as `abt_inum` or younger, starting at the next cycle. A load offered in the same cycle with an instruction number the same age as `abt_inum` or younger is not recorded.
- R5: A check (`chk_valid`) makes `viol_valid` high in the following cycle if and only if some occupied slot has a tag equal to `chk_addr[11:0]` and a load younger than `chk_inum`. Otherwise `viol_valid` is low in that cycle.
- R6: Address bits above bit 11 take no part in the compare, so a store differing from a load only in upper bits still reports a violation.
- R7: When several slots match, `viol_inum` is the instruction number of the oldest matching load.
- R8: Slots that an abort in the same cycle is removing are excluded from that cycle's check.
- R9: A load recorded in the same cycle as a check is not seen by that check. It is seen by checks in later cycles.
- R10: Age is modulo 256: a is younger than b when (a - b) mod 256 lies in 1..127. This ordering holds across the wrap from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exe_valid | input | 1 | Load execute request |
| exe_ready | output | 1 | A free slot exists |
| exe_inum | input | 8 | Instruction number of the executing load |
| exe_addr | input | 32 | Address of the executing load |
| cmt_valid | input | 1 | Load commit strobe |
| cmt_inum | input | 8 | Instruction number of the committing load |
| abt_valid | input | 1 | Abort strobe |
| abt_inum | input | 8 | Oldest instruction number being aborted |
| chk_valid | input | 1 | Store address check strobe |
| chk_inum | input | 8 | Instruction number of the store |
| chk_addr | input | 32 | Resolved store address |
| viol_valid | output | 1 | Violation found by the previous cycle's check |
| viol_inum | output | 8 | Instruction number of the oldest offending load |

## Verification
`exe_ready` depends only on slot occupancy, so the bench samples it a nanosecond after it drives each cycle's inputs, before the edge that would accept the load. The violation result is registered: a check applied before edge k is compared at the falling edge after edge k. Expected values come from slot contents as they stood before that edge, minus the slots an abort in the same cycle removes. Commits, aborts and new loads change the reference model only at that edge, which matches the one-cycle delay of the slot registers.

// File: rtl/slvd_pkg.sv
package slvd_pkg;
  localparam int DEF_SLOTS  = 16;
  localparam int DEF_INUM_W = 8;
  localparam int DEF_ADDR_W = 32;
  localparam int DEF_TAG_W  = 12;
endpackage

// File: rtl/slvd_slot.sv
module slvd_slot #(
  parameter int IW = 8,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [IW-1:0] alloc_inum,
  input  logic [TW-1:0] alloc_tag,
  input  logic          cmt_valid,
  input  logic [IW-1:0] cmt_inum,
  input  logic          abt_valid,
  input  logic [IW-1:0] abt_inum,
  input  logic          chk_valid,
  input  logic [IW-1:0] chk_inum,
  input  logic [TW-1:0] chk_tag,
  output logic          busy,
  output logic [IW-1:0] inum,
  output logic          hit
);
  logic [TW-1:0] tag_q;
  logic [IW-1:0] d_abt, d_chk;
  logic          kill, retire;

  always_comb begin
    d_abt  = inum - abt_inum;
    d_chk  = inum - chk_inum;
    kill   = abt_valid & busy & ~d_abt[IW-1];
    retire = cmt_valid & busy & (inum == cmt_inum);
    hit    = busy & ~kill & chk_valid & (tag_q == chk_tag) &
             (d_chk != '0) & ~d_chk[IW-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      inum  <= '0;
      tag_q <= '0;
    end else if (alloc) begin
      busy  <= 1'b1;
      inum  <= alloc_inum;
      tag_q <= alloc_tag;
    end else if (kill | retire) begin
      busy  <= 1'b0;
    end
  end
endmodule

// File: rtl/slvd_alloc.sv
module slvd_alloc #(
  parameter int N = 16
) (
  input  logic [N-1:0] busy,
  output logic [N-1:0] grant,
  output logic         any_free
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) grant = N'(1) << i;
    end
    any_free = ~&busy;
  end
endmodule

// File: rtl/slvd_oldest.sv
module slvd_oldest #(
  parameter int N  = 16,
  parameter int IW = 8
) (
  input  logic [N-1:0]    hit,
  input  logic [N*IW-1:0] inums,
  output logic            found,
  output logic [IW-1:0]   oldest
);
  logic [IW-1:0] cand, diff;
  always_comb begin
    found  = 1'b0;
    oldest = '0;
    for (int i = 0; i < N; i++) begin
      cand = inums[i*IW +: IW];
      diff = oldest - cand;
      if (hit[i] && (!found || ((diff != '0) && !diff[IW-1]))) begin
        oldest = cand;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/slvd_detector.sv
module slvd_detector
  import slvd_pkg::*;
#(
  parameter int SLOTS  = DEF_SLOTS,
  parameter int INUM_W = DEF_INUM_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int TAG_W  = DEF_TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exe_valid,
  output logic              exe_ready,
  input  logic [INUM_W-1:0] exe_inum,
  input  logic [ADDR_W-1:0] exe_addr,
  input  logic              cmt_valid,
  input  logic [INUM_W-1:0] cmt_inum,
  input  logic              abt_valid,
  input  logic [INUM_W-1:0] abt_inum,
  input  logic              chk_valid,
  input  logic [INUM_W-1:0] chk_inum,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              viol_valid,
  output logic [INUM_W-1:0] viol_inum
);
  localparam int FLAT_W = SLOTS * INUM_W;

  logic [SLOTS-1:0]  slot_busy, slot_hit, grant;
  logic [FLAT_W-1:0] slot_inum_flat;
  logic              any_free, exe_drop, exe_fire, found;
  logic [INUM_W-1:0] d_exe, oldest;
  logic [TAG_W-1:0]  exe_tag, chk_tag;

  assign exe_tag = exe_addr[TAG_W-1:0];
  assign chk_tag = chk_addr[TAG_W-1:0];

  slvd_alloc #(.N(SLOTS)) u_alloc (
    .busy(slot_busy), .grant(grant), .any_free(any_free)
  );

  always_comb begin
    d_exe     = exe_inum - abt_inum;
    exe_drop  = abt_valid & ~d_exe[INUM_W-1];
    exe_ready = any_free;
    exe_fire  = exe_valid & any_free & ~exe_drop;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    slvd_slot #(.IW(INUM_W), .TW(TAG_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc(exe_fire & grant[g]),
      .alloc_inum(exe_inum), .alloc_tag(exe_tag),
      .cmt_valid(cmt_valid), .cmt_inum(cmt_inum),
      .abt_valid(abt_valid), .abt_inum(abt_inum),
      .chk_valid(chk_valid), .chk_inum(chk_inum), .chk_tag(chk_tag),
      .busy(slot_busy[g]),
      .inum(slot_inum_flat[g*INUM_W +: INUM_W]),
      .hit(slot_hit[g])
    );
  end

  slvd_oldest #(.N(SLOTS), .IW(INUM_W)) u_oldest (
    .hit(slot_hit), .inums(slot_inum_flat), .found(found), .oldest(oldest)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_inum  <= '0;
    end else begin
      viol_valid <= found;
      viol_inum  <= found ? oldest : '0;
    end
  end
endmodule

// File: rtl/slvd_checker.sv
module slvd_checker #(
  parameter int N  = 16,
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chk_valid,
  input logic [IW-1:0] chk_inum,
  input logic          abt_valid,
  input logic [IW-1:0] abt_inum,
  input logic          viol_valid,
  input logic [IW-1:0] viol_inum,
  input logic [N-1:0]  busy,
  input logic [N*IW-1:0] inums,
  input logic [N-1:0]  grant
);
  function automatic logic younger(input logic [IW-1:0] a, input logic [IW-1:0] b);
    logic [IW-1:0] d;
    d = a - b;
    return (d != '0) && !d[IW-1];
  endfunction

  function automatic logic stale(input logic [N-1:0] bz, input logic [N*IW-1:0] nums,
                                 input logic [IW-1:0] cut);
    logic r;
    logic [IW-1:0] d;
    r = 1'b0;
    for (int i = 0; i < N; i++) begin
      d = nums[i*IW +: IW] - cut;
      if (bz[i] && !d[IW-1]) r = 1'b1;
    end
    return r;
  endfunction

  assert_viol_after_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(chk_valid));

  assert_viol_is_younger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> younger(viol_inum, $past(chk_inum)));

  assert_abort_sweeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abt_valid) |-> !stale(busy, inums, $past(abt_inum)));

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

bind slvd_detector slvd_checker #(.N(SLOTS), .IW(INUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .chk_valid(chk_valid), .chk_inum(chk_inum),
  .abt_valid(abt_valid), .abt_inum(abt_inum),
  .viol_valid(viol_valid), .viol_inum(viol_inum),
  .busy(slot_busy), .inums(slot_inum_flat), .grant(grant)
);

// File: tb/slvd_detector_test.sv
`timescale 1ns/1ps
module slvd_detector_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exe_valid = 0, cmt_valid = 0, abt_valid = 0, chk_valid = 0;
  logic [7:0] exe_inum = 0, cmt_inum = 0, abt_inum = 0, chk_inum = 0;
  logic [31:0] exe_addr = 0, chk_addr = 0;
  logic exe_ready, viol_valid;
  logic [7:0] viol_inum;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit last_fire;
  bit mv [16];
  logic [7:0] mi [16];
  logic [11:0] mt [16];

  always #4 clk = ~clk;

  slvd_detector uut (
    .clk(clk), .rst_n(rst_n),
    .exe_valid(exe_valid), .exe_ready(exe_ready), .exe_inum(exe_inum), .exe_addr(exe_addr),
    .cmt_valid(cmt_valid), .cmt_inum(cmt_inum),
    .abt_valid(abt_valid), .abt_inum(abt_inum),
    .chk_valid(chk_valid), .chk_inum(chk_inum), .chk_addr(chk_addr),
    .viol_valid(viol_valid), .viol_inum(viol_inum)
  );

  function automatic bit yng(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] d;
    d = a - b;
    return (d != 0) && !d[7];
  endfunction

  function automatic bit same_or_yng(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] d;
    d = a - b;
    return !d[7];
  endfunction

  task automatic check(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic step(input bit lv, input logic [7:0] li, input logic [31:0] la,
                      input bit cv, input logic [7:0] ci,
                      input bit av, input logic [7:0] ai,
                      input bit sv, input logic [7:0] si, input logic [31:0] sa,
                      input string rq);
    int cnt, freej;
    bit ev, fire;
    logic [7:0] ei;
    exe_valid = lv; exe_inum = li; exe_addr = la;
    cmt_valid = cv; cmt_inum = ci;
    abt_valid = av; abt_inum = ai;
    chk_valid = sv; chk_inum = si; chk_addr = sa;
    #1;
    cnt = 0; freej = -1;
    for (int k = 0; k < 16; k++) begin
      if (mv[k]) cnt++;
      else if (freej < 0) freej = k;
    end
    check("R2", "exe_ready", exe_ready, cnt < 16);
    ev = 0; ei = 0;
    for (int k = 0; k < 16; k++) begin
      if (sv && mv[k] && !(av && same_or_yng(mi[k], ai)) && mt[k] == sa[11:0] && yng(mi[k], si)) begin
        if (!ev || yng(ei, mi[k])) ei = mi[k];
        ev = 1;
      end
    end
    fire = lv && (cnt < 16) && !(av && same_or_yng(li, ai));
    last_fire = fire;
    @(posedge clk);
    for (int k = 0; k < 16; k++) begin
      if (mv[k] && av && same_or_yng(mi[k], ai)) mv[k] = 0;
      else if (mv[k] && cv && mi[k] == ci) mv[k] = 0;
    end
    if (fire) begin
      mv[freej] = 1; mi[freej] = li; mt[freej] = la[11:0];
    end
    @(negedge clk);
    check(rq, "viol_valid", viol_valid, ev);
    if (ev) check(rq, "viol_inum", viol_inum, ei);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] nxt;
    logic [31:0] seed;
    logic [11:0] pool [4];
    pool[0] = 12'h010; pool[1] = 12'h020; pool[2] = 12'h030; pool[3] = 12'h040;
    for (int k = 0; k < 16; k++) begin mv[k] = 0; mi[k] = 0; mt[k] = 0; end
    seed = $urandom(32'd1357);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R1", "exe_ready", exe_ready, 1);
    check("R1", "viol_valid", viol_valid, 0);

    // Directed corner cases
    step(1, 10, 32'h1234_5100, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 11, 32'h0000_0200, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 1, 9, 32'hABCD_E100, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 1, 12, 32'h0000_0100, "R10");
    step(1, 13, 32'h0000_0300, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 14, 32'h0000_0300, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 1, 12, 32'h0000_7300, "R7");
    step(0, 0, 0, 1, 10, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 0, 1, 9, 32'h0000_0100, "R3");
    step(0, 0, 0, 0, 0, 1, 13, 1, 12, 32'h0000_0300, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 1, 12, 32'h0000_0300, "R4");
    step(1, 20, 32'h0000_0500, 0, 0, 0, 0, 1, 19, 32'h0000_0500, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 1, 19, 32'h0000_0500, "R9");
    step(1, 21, 32'h0000_0600, 0, 0, 1, 21, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 1, 19, 32'h0000_0600, "R4");
    for (int k = 0; k < 14; k++) step(1, 8'(30 + k), 32'h0000_0800, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 44, 32'h0000_0700, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 1, 29, 32'h0000_0700, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 1, 29, 32'h0000_0800, "R7");
    step(0, 0, 0, 0, 0, 1, 11, 0, 0, 0, "R4");
    step(1, 250, 32'h0000_0900, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 3, 32'h0000_0900, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 1, 252, 32'h0000_0900, "R10");
    step(0, 0, 0, 0, 0, 1, 250, 0, 0, 0, "R4");
    idle();

    // Constrained random traffic
    nxt = 8'd4;
    for (int c = 0; c < 3000; c++) begin
      bit lv, cv, av, sv;
      logic [7:0] ci, ai, si, oldest;
      logic [31:0] la, sa;
      bit have;
      lv = ($urandom % 2) == 0;
      la = {$urandom % 32'h000F_FFFF, pool[$urandom % 4]};
      sv = ($urandom % 5) < 2;
      si = nxt - 8'd1 - 8'($urandom % 20);
      sa = {$urandom % 32'h000F_FFFF, pool[$urandom % 4]};
      have = 0; oldest = 0;
      for (int k = 0; k < 16; k++)
        if (mv[k] && (!have || yng(oldest, mi[k]))) begin oldest = mi[k]; have = 1; end
      cv = have && (($urandom % 10) < 3);
      ci = oldest;
      av = ($urandom % 20) == 0;
      ai = nxt - 8'($urandom % 4);
      step(lv, nxt, la, cv, ci, av, ai, sv, si, sa, "R5");
      if (last_fire) nxt = nxt + 8'd1;
      if (av) nxt = ai;
    end
    idle();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule